// File: doc/BRIEF.md
# Vectored Multi-Source Interrupt Controller

This block lets a processor that owns a single interrupt line and one fixed vector slot serve several interrupt sources, each with its own handler. Every source has a request input that is detected on its rising edge and latched as a sticky pending bit. Software fills a small table with one handler branch word per source through a control/data register pair, and enables or disables sources with separate set-mask and clear-mask commands. It can also raise a source by command.

When the controller is idle and at least one enabled source is pending, it picks the lowest-numbered one. It clears that source's pending bit and copies the source's branch word into an output buffer. One cycle later it raises the interrupt request to the processor. The buffer is presented on `code_out`, and the processor's acknowledge steers it onto the instruction fetch path through a multiplexer outside this block. The request drops after the acknowledge. No further source is chosen until the processor pulses its return-from-interrupt strobe.

The sequencer has four states. `ST_IDLE` waits for an eligible source. `ST_LOAD` holds the freshly loaded buffer for one cycle. `ST_ARM` drives the request until it is acknowledged. `ST_SERVE` waits for the return strobe. The transitions are: IDLE to LOAD on an eligible pending source (*take*). LOAD to ARM unconditionally (*raise*). ARM to SERVE on `cpu_ack` (*taken*). SERVE to IDLE on `cpu_rti` (*done*). Every state holds when its condition is absent.

Top module: `vic_ctrl`

## Requirements
- R1: A source becomes pending only when its request input was low in the previous cycle and is high in this one. A level held high does not raise the source again after it has been served.
- R2: A pending bit is sticky. Further rising edges on a source that is already pending add nothing, so the source is served exactly once.
- R3: Among sources that are both pending and enabled, the lowest-numbered one is served first.
- R4: The selected branch word appears on `code_out` on the clock edge after the source becomes pending. `cpu_irq` rises one clock edge later, so a source's edge reaches `cpu_irq` three clock edges after the input is driven high.
- R5: While a service is open, meaning between selection and the `cpu_rti` pulse, no other source is selected and `cpu_irq` stays low after the acknowledge. Sources arriving meanwhile stay pending and are served after `cpu_rti`.
- R6: A write with `reg_sel`=0 is a command: the code is in `reg_wdata[7:0]` and the mask is in `reg_wdata[8+N-1:8]`. Code 0x02 sets the enable bit of every source whose mask bit is 1; zero mask bits leave enables unchanged.
- R7: Command code 0x04 clears the enable bit of every source whose mask bit is 1, leaving the others unchanged. A disabled source is not served.
- R8: Command code 0x08 sets the pending bit of every source whose mask bit is 1 (software trigger).
- R9: Command code 0x01 takes an entry number from `reg_wdata[8+IW-1:8]`. A write with `reg_sel`=1 stores the full `reg_wdata` word into that table entry, and that word is what the source later presents on `code_out`.
- R10: `ctrl_rdata` returns the enable bitmap in its low N bits, with bit i for source i, and zero above.
- R11: A pending source that is not enabled is never selected but stays pending. It is served once it is enabled.
- R12: `cpu_irq` stays high from the end of the load cycle until `cpu_ack` is sampled, and is low from the next cycle. The selected source's pending bit is cleared at selection.
- R13: Synchronous active-high reset clears the enables, the pending bits, the sequencer state, the entry pointer, the output buffer and `cpu_irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_in | input | N_SRC | Interrupt request lines, rising-edge detected |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the command register, 1 selects the table data register |
| reg_wdata | input | WORD_W | Register write data |
| ctrl_rdata | output | WORD_W | Enable bitmap readback |
| cpu_ack | input | 1 | Processor acknowledge of the interrupt request |
| cpu_rti | input | 1 | Processor return-from-interrupt strobe |
| cpu_irq | output | 1 | Interrupt request to the processor |
| code_out | output | WORD_W | Branch word of the source being served |

## Verification
A corrupted pending or enable bit shows up at the ports as a wrong or missing branch word on `code_out`, or as a `cpu_irq` that appears when it should not. This is visible two or three cycles after the controller returns to idle. A sequencer stuck in or skipping a state shows directly on `cpu_irq`: the request either never rises or survives the acknowledge by a cycle. The bench's per-clock reference model compares `cpu_irq`, `code_out` and `ctrl_rdata` on every cycle, so such a divergence is reported in the cycle it first reaches a port.

// File: rtl/vic_pkg.sv
package vic_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_ARM,
        ST_SERVE
    } vic_state_e;

    localparam logic [7:0] CMD_SELECT  = 8'h01;
    localparam logic [7:0] CMD_ENABLE  = 8'h02;
    localparam logic [7:0] CMD_DISABLE = 8'h04;
    localparam logic [7:0] CMD_TRIGGER = 8'h08;
    localparam int         ARG_LSB     = 8;
endpackage

// File: rtl/vic_edge.sv
module vic_edge #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] lvl_i,
    output logic [N-1:0] rise_o
);
    logic [N-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= lvl_i;
    end

    assign rise_o = lvl_i & ~prev_q;

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (rise_o & $past(rise_o)) == '0); // R1
endmodule

// File: rtl/vic_pick.sv
module vic_pick #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic [N-1:0]  req_i,
    output logic          valid_o,
    output logic [IW-1:0] idx_o
);
    always_comb begin
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) idx_o = IW'(i);
        end
    end

    assign valid_o = |req_i;
endmodule

// File: rtl/vic_table.sv
module vic_table #(
    parameter int N  = 8,
    parameter int W  = 32,
    parameter int IW = 3
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [IW-1:0] waddr_i,
    input  logic [W-1:0]  wdata_i,
    input  logic [IW-1:0] raddr_i,
    output logic [W-1:0]  rdata_o
);
    logic [W-1:0] mem [N];

    always_ff @(posedge clk) begin
        if (we_i && (int'(waddr_i) < N)) mem[waddr_i] <= wdata_i;
    end

    assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/vic_ctrl.sv
module vic_ctrl
    import vic_pkg::*;
#(
    parameter int N_SRC  = 8,
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_SRC-1:0]  req_in,
    input  logic              reg_we,
    input  logic              reg_sel,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] ctrl_rdata,
    input  logic              cpu_ack,
    input  logic              cpu_rti,
    output logic              cpu_irq,
    output logic [WORD_W-1:0] code_out
);
    localparam int IW = (N_SRC > 1) ? $clog2(N_SRC) : 1;

    vic_state_e        state_q, state_d;
    logic [N_SRC-1:0]  pend_q, en_q, rise, sw_set, clr_vec, eligible, mask;
    logic [IW-1:0]     sel_q, pick_idx;
    logic              pick_valid, take, ctrl_wr, data_wr;
    logic [7:0]        cmd;
    logic [WORD_W-1:0] buf_q, tbl_rdata;

    assign ctrl_wr = reg_we && !reg_sel;
    assign data_wr = reg_we && reg_sel;
    assign cmd     = reg_wdata[7:0];
    assign mask    = reg_wdata[ARG_LSB +: N_SRC];
    assign sw_set  = (ctrl_wr && cmd == CMD_TRIGGER) ? mask : '0;

    vic_edge #(.N(N_SRC)) u_edge (
        .clk(clk), .rst(rst), .lvl_i(req_in), .rise_o(rise)
    );

    assign eligible = pend_q & en_q;

    vic_pick #(.N(N_SRC), .IW(IW)) u_pick (
        .req_i(eligible), .valid_o(pick_valid), .idx_o(pick_idx)
    );

    vic_table #(.N(N_SRC), .W(WORD_W), .IW(IW)) u_table (
        .clk(clk), .we_i(data_wr), .waddr_i(sel_q), .wdata_i(reg_wdata),
        .raddr_i(pick_idx), .rdata_o(tbl_rdata)
    );

    assign take    = (state_q == ST_IDLE) && pick_valid;
    assign clr_vec = take ? (N_SRC'(1) << pick_idx) : '0;

    // sequencer: next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (pick_valid) state_d = ST_LOAD;
            ST_LOAD:  state_d = ST_ARM;
            ST_ARM:   if (cpu_ack) state_d = ST_SERVE;
            ST_SERVE: if (cpu_rti) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // sequencer: state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // source bookkeeping and table pointer
    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            en_q   <= '0;
            sel_q  <= '0;
            buf_q  <= '0;
        end else begin
            pend_q <= (pend_q & ~clr_vec) | rise | sw_set;
            if (ctrl_wr && cmd == CMD_ENABLE)  en_q  <= en_q | mask;
            if (ctrl_wr && cmd == CMD_DISABLE) en_q  <= en_q & ~mask;
            if (ctrl_wr && cmd == CMD_SELECT)  sel_q <= reg_wdata[ARG_LSB +: IW];
            if (take)                          buf_q <= tbl_rdata;
        end
    end

    // outputs
    always_comb begin
        cpu_irq    = (state_q == ST_ARM);
        code_out   = buf_q;
        ctrl_rdata = WORD_W'(en_q);
    end

    AST_PICK_LOWEST: assert property (@(posedge clk) disable iff (rst)
        pick_valid |-> (eligible[pick_idx] &&
            ((eligible & ((N_SRC'(1) << pick_idx) - N_SRC'(1))) == '0))); // R3
    AST_CODE_BEFORE_IRQ: assert property (@(posedge clk) disable iff (rst)
        $rose(cpu_irq) |-> $stable(code_out)); // R4
    AST_QUIET_IN_SERVICE: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SERVE && !cpu_rti) |=> !cpu_irq); // R5
    AST_DISABLED_NOT_TAKEN: assert property (@(posedge clk) disable iff (rst)
        take |-> en_q[pick_idx]); // R11
    AST_IRQ_DROPS_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
        (cpu_irq && cpu_ack) |=> !cpu_irq); // R12
    AST_SELECT_CLEARS_PEND: assert property (@(posedge clk) disable iff (rst)
        (take && !rise[pick_idx] && !sw_set[pick_idx]) |=> !pend_q[$past(pick_idx)]); // R12
endmodule

// File: tb/vic_ctrl_test.sv
module vic_ctrl_test;
    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  req_in = '0;
    logic        reg_we = 1'b0, reg_sel = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] ctrl_rdata, code_out;
    logic        cpu_ack = 1'b0, cpu_rti = 1'b0, cpu_irq;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit model_live = 1'b0;

    always #5 clk = ~clk;

    vic_ctrl #(.N_SRC(N), .WORD_W(32)) uut (
        .clk(clk), .rst(rst), .req_in(req_in), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .ctrl_rdata(ctrl_rdata), .cpu_ack(cpu_ack),
        .cpu_rti(cpu_rti), .cpu_irq(cpu_irq), .code_out(code_out)
    );

    // behavioural reference model, updated on every rising edge
    logic [7:0]  m_prev, m_pend, m_en;
    int          m_state, m_sel;
    logic [31:0] m_buf;
    logic [31:0] m_tab [N];

    always @(posedge clk) begin : model
        logic [7:0] m_set, m_clr, m_mask;
        int pick;
        cycles++;
        if (rst) begin
            m_prev = '0; m_pend = '0; m_en = '0;
            m_state = 0; m_sel = 0; m_buf = '0;
        end else begin
            m_mask = reg_wdata[15:8];
            m_set  = req_in & ~m_prev;
            if (reg_we && !reg_sel && reg_wdata[7:0] == 8'h08) m_set = m_set | m_mask;
            m_clr = '0;
            case (m_state)
                0: begin
                    pick = -1;
                    for (int i = N - 1; i >= 0; i--) if (m_pend[i] && m_en[i]) pick = i;
                    if (pick >= 0) begin
                        m_buf = m_tab[pick];
                        m_clr[pick] = 1'b1;
                        m_state = 1;
                    end
                end
                1: m_state = 2;
                2: if (cpu_ack) m_state = 3;
                default: if (cpu_rti) m_state = 0;
            endcase
            m_pend = (m_pend & ~m_clr) | m_set;
            if (reg_we && !reg_sel) begin
                if (reg_wdata[7:0] == 8'h02) m_en = m_en | m_mask;
                if (reg_wdata[7:0] == 8'h04) m_en = m_en & ~m_mask;
                if (reg_wdata[7:0] == 8'h01) m_sel = int'(reg_wdata[10:8]);
            end
            if (reg_we && reg_sel) m_tab[m_sel] = reg_wdata;
            m_prev = req_in;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // every-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (model_live && !rst) begin
            check("R12 model cpu_irq", {31'b0, cpu_irq}, {31'b0, (m_state == 2)});
            check("R9 model code_out", code_out, m_buf);
            check("R10 model ctrl_rdata", ctrl_rdata, {24'b0, m_en});
        end
    end

    always @(posedge clk) begin
        if (cycles >= 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr_cmd(input logic [7:0] code, input logic [7:0] arg);
        reg_we = 1'b1; reg_sel = 1'b0; reg_wdata = {16'b0, arg, code};
        tick();
        reg_we = 1'b0;
    endtask

    task automatic wr_data(input logic [31:0] w);
        reg_we = 1'b1; reg_sel = 1'b1; reg_wdata = w;
        tick();
        reg_we = 1'b0; reg_sel = 1'b0;
    endtask

    task automatic wait_irq(input string tag);
        int n = 0;
        while (!cpu_irq && n < 40) begin
            tick();
            n++;
        end
        check(tag, {31'b0, cpu_irq}, 32'd1);
    endtask

    task automatic ack_and_return();
        cpu_ack = 1'b1; tick(); cpu_ack = 1'b0;
        tick();
        cpu_rti = 1'b1; tick(); cpu_rti = 1'b0;
        tick();
    endtask

    task automatic quiet(input string tag, input int n);
        for (int k = 0; k < n; k++) begin
            tick();
            check(tag, {31'b0, cpu_irq}, 32'd0);
        end
    endtask

    function automatic logic [31:0] word(input int i);
        return 32'hE700_0000 | (i * 32'h111);
    endfunction

    initial begin
        tick(); tick(); tick();
        rst = 1'b0;
        model_live = 1'b1;
        tick();
        check("R13 reset cpu_irq", {31'b0, cpu_irq}, 32'd0);
        check("R13 reset code_out", code_out, 32'd0);
        check("R13 reset enables", ctrl_rdata, 32'd0);

        for (int i = 0; i < N; i++) begin
            wr_cmd(8'h01, 8'(i));
            wr_data(word(i));
        end

        wr_cmd(8'h02, 8'h0F);
        check("R6 enable set", ctrl_rdata, 32'h0F);
        wr_cmd(8'h02, 8'h00);
        check("R6 zero mask keeps enables", ctrl_rdata, 32'h0F);
        wr_cmd(8'h04, 8'h02);
        check("R7 disable bit 1 only", ctrl_rdata, 32'h0D);
        wr_cmd(8'h02, 8'h20);
        check("R10 bitmap readback", ctrl_rdata, 32'h2D);

        // latency and lowest-first: sources 3 and 0 rise together
        req_in[3] = 1'b1; req_in[0] = 1'b1;
        tick();
        check("R4 no irq after pend edge", {31'b0, cpu_irq}, 32'd0);
        tick();
        check("R4 irq still low in load", {31'b0, cpu_irq}, 32'd0);
        check("R4 word loaded before irq", code_out, word(0));
        tick();
        check("R4 irq raised", {31'b0, cpu_irq}, 32'd1);
        check("R3 lowest source first", code_out, word(0));
        tick();
        check("R12 irq held until ack", {31'b0, cpu_irq}, 32'd1);
        cpu_ack = 1'b1; tick(); cpu_ack = 1'b0;
        check("R12 irq low after ack", {31'b0, cpu_irq}, 32'd0);

        // arrivals during service, with repeated edges on source 5
        req_in[2] = 1'b1; tick();
        req_in[5] = 1'b1; tick(); req_in[5] = 1'b0; tick();
        req_in[5] = 1'b1; tick(); req_in[5] = 1'b0;
        quiet("R5 no irq in service", 4);
        cpu_rti = 1'b1; tick(); cpu_rti = 1'b0;

        wait_irq("R5 pending served after rti");
        check("R3 source 2 before 3 and 5", code_out, word(2));
        ack_and_return();
        wait_irq("R3 next source");
        check("R3 source 3 next", code_out, word(3));
        ack_and_return();
        wait_irq("R2 source 5 served");
        check("R2 source 5 word", code_out, word(5));
        ack_and_return();
        quiet("R2 R1 no repeat service", 10);
        req_in = '0;
        tick();

        // disabled source stays pending
        req_in[1] = 1'b1; tick(); req_in[1] = 1'b0;
        quiet("R11 disabled not served", 10);
        wr_cmd(8'h02, 8'h02);
        wait_irq("R11 served once enabled");
        check("R11 source 1 word", code_out, word(1));
        ack_and_return();

        // software trigger
        wr_cmd(8'h02, 8'h40);
        wr_cmd(8'h08, 8'h40);
        wait_irq("R8 software trigger");
        check("R8 source 6 word", code_out, word(6));
        ack_and_return();

        // table rewrite
        wr_cmd(8'h01, 8'h06);
        wr_data(32'hE7AB_CDEF);
        wr_cmd(8'h08, 8'h40);
        wait_irq("R9 rewritten entry");
        check("R9 new word presented", code_out, 32'hE7AB_CDEF);
        ack_and_return();

        // everything disabled
        wr_cmd(8'h04, 8'hFF);
        check("R7 all disabled", ctrl_rdata, 32'd0);
        wr_cmd(8'h08, 8'h01);
        quiet("R7 disabled trigger ignored", 8);

        // reset clears the pending trigger
        rst = 1'b1; tick(); tick(); rst = 1'b0;
        tick();
        check("R13 enables cleared", ctrl_rdata, 32'd0);
        wr_cmd(8'h02, 8'h01);
        quiet("R13 pending cleared by reset", 10);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule